// File: doc/BRIEF.md
# VoQ Credit Request/Grant Scheduler

This block is the ingress queueing stage of a virtual-output-queue switch, together with a small egress grant arbiter for every output. Each of `N_IN` inputs holds one descriptor queue for every one of the `N_OUT` outputs. An arriving descriptor is steered into the queue named by its destination. A queue that holds descriptors raises a credit request toward its output. Nothing leaves a queue until that output's arbiter answers with a grant naming the queue. The path is the same when the input and output indices are equal, which is the locally switched case.

Each output has one round-robin arbiter. It issues a grant only in a cycle where its output offers a transfer slot (`out_ready`). A grant releases exactly one descriptor. The descriptor appears on the output with the index of the input it came from. Requests are registered, so they lag the queue state by one cycle. A queue that has just drained can therefore still attract one last grant. That grant finds the queue empty and is counted as wasted. Arrivals to a full queue are dropped and counted per queue.

Queue state machine (one per input/output pair): `Q_EMPTY` to `Q_PART` (or straight to `Q_FULL` when the depth is one) on an accepted arrival. `Q_PART` to `Q_FULL` when the fill reaches the depth. `Q_PART` to `Q_EMPTY` when the last entry is taken. `Q_FULL` to `Q_PART` or `Q_EMPTY` on a take. Arbiter state machine (one per output): `ARB_IDLE` to `ARB_GRANT` when the slot is offered and any request is seen. `ARB_GRANT` always returns to `ARB_IDLE` after one cycle.

Top module: `voq_sched`

## Requirements
- R1: A descriptor presented with `in_vld[i]` and destination `in_dst[i]` enters queue (i, dst). Descriptors from one input to one output leave in the order they arrived.
- R2: A descriptor appears on output o (`out_vld[o]`=1) only if `out_ready[o]` was high in the previous cycle. While `out_ready[o]` stays low, no descriptor leaves for o.
- R3: Request bit `voq_req[i*N_OUT+o]` rises two clock edges after the first arrival to an empty queue (i, o). It stays high while the queue holds entries and clears after the queue drains. A grant is only issued to a queue whose request bit was high in the grant-decision cycle.
- R4: Locally switched traffic (i equal to o) waits for a grant exactly like any other traffic.
- R5: When several inputs request one output, grants go round-robin. The search starts at the input after the last one granted, and starts at input 0 after reset.
- R6: Each grant releases exactly one descriptor. `out_vld[o]` is a one-cycle pulse with `out_src[o]` naming the source input. An output never shows `out_vld` in two consecutive cycles.
- R7: A grant that finds its queue empty produces no output and increments `wasted_cnt[o]` by one. When a queue that is the sole remaining requester of an output drains, exactly one such grant follows.
- R8: An arrival to a queue holding `DEPTH` entries is discarded. The queue's field of `drop_cnt` (index i*N_OUT+o) increases by one.
- R9: After reset, no output is valid and all requests and counters read zero.
- R10: Different outputs grant independently and may release descriptors in the same cycle, including two descriptors from one input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_vld | input | N_IN | Descriptor arrival strobe per input |
| in_dst | input | N_IN*OW | Destination output per input |
| in_data | input | N_IN*DW | Descriptor value per input |
| out_ready | input | N_OUT | Transfer slot offered by each output |
| out_vld | output | N_OUT | Descriptor released on each output |
| out_src | output | N_OUT*IW | Source input of the released descriptor |
| out_data | output | N_OUT*DW | Released descriptor value |
| voq_req | output | N_IN*N_OUT | Registered credit request per queue |
| drop_cnt | output | N_IN*N_OUT*CW | Arrivals discarded per queue |
| wasted_cnt | output | N_OUT*CW | Grants that met an empty queue, per output |

## Verification
A held-slot pattern fills a queue while its output offers no slot. This shows that requests rise but nothing leaves until a slot appears, for remote and local traffic alike. A three-way contention pattern on one output separates true rotation from fixed priority, and from serving one input to exhaustion. A lone single-descriptor pattern exposes the stale-request wasted grant. An overfill pattern separates dropping the newest arrival from overwriting older entries. A two-output release in one cycle separates independent arbiters from a shared one.

// File: rtl/voq_pkg.sv
package voq_pkg;

    typedef enum logic [1:0] {
        Q_EMPTY = 2'd0,
        Q_PART  = 2'd1,
        Q_FULL  = 2'd2
    } qstate_e;

    typedef enum logic {
        ARB_IDLE  = 1'b0,
        ARB_GRANT = 1'b1
    } arb_state_e;

endpackage

// File: rtl/voq_queue.sv
module voq_queue
    import voq_pkg::*;
#(
    parameter int DEPTH = 4,
    parameter int DW    = 8,
    parameter int CW    = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [DW-1:0] push_data,
    input  logic          pop,
    output logic [DW-1:0] head_data,
    output logic          nonempty,
    output logic          req,
    output logic [CW-1:0] drop_cnt
);

    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int NW = $clog2(DEPTH + 1);
    localparam logic [NW-1:0] FULL_N = NW'(DEPTH);
    localparam logic [AW-1:0] LAST   = AW'(DEPTH - 1);

    logic [DW-1:0] slots [DEPTH];
    logic [AW-1:0] rd_q, wr_q;
    logic [NW-1:0] fill_q, fill_d;
    logic [CW-1:0] drop_q;
    logic          req_q;
    logic          accept, take;
    qstate_e       st_q, st_d;

    function automatic logic [AW-1:0] step(input logic [AW-1:0] p);
        return (p == LAST) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        accept = push && (st_q != Q_FULL);
        take   = pop && (st_q != Q_EMPTY);
        fill_d = fill_q;
        if (accept && !take) begin
            fill_d = fill_q + 1'b1;
        end else if (take && !accept) begin
            fill_d = fill_q - 1'b1;
        end
    end

    // next-state logic
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            Q_EMPTY: if (accept) st_d = (fill_d == FULL_N) ? Q_FULL : Q_PART;
            Q_PART: begin
                if (fill_d == '0) begin
                    st_d = Q_EMPTY;
                end else if (fill_d == FULL_N) begin
                    st_d = Q_FULL;
                end
            end
            Q_FULL:  if (take) st_d = (fill_d == '0) ? Q_EMPTY : Q_PART;
            default: st_d = Q_EMPTY;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q   <= Q_EMPTY;
            fill_q <= '0;
            rd_q   <= '0;
            wr_q   <= '0;
            req_q  <= 1'b0;
            drop_q <= '0;
        end else begin
            st_q   <= st_d;
            fill_q <= fill_d;
            if (accept) wr_q <= step(wr_q);
            if (take)   rd_q <= step(rd_q);
            req_q  <= (st_q != Q_EMPTY);
            if (push && (st_q == Q_FULL) && (drop_q != '1)) begin
                drop_q <= drop_q + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (accept) slots[wr_q] <= push_data;
    end

    // outputs
    always_comb begin
        head_data = slots[rd_q];
        nonempty  = (st_q != Q_EMPTY);
        req       = req_q;
        drop_cnt  = drop_q;
    end

endmodule

// File: rtl/voq_rr_arb.sv
module voq_rr_arb
    import voq_pkg::*;
#(
    parameter int N_IN = 4,
    parameter int IW   = (N_IN > 1) ? $clog2(N_IN) : 1,
    parameter int CW   = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [N_IN-1:0] req,
    input  logic            slot,
    input  logic            hit,
    output logic            grant_vld,
    output logic [IW-1:0]   grant_idx,
    output logic [CW-1:0]   wasted_cnt
);

    localparam logic [IW-1:0] TOP = IW'(N_IN - 1);

    arb_state_e    st_q, st_d;
    logic [IW-1:0] ptr_q, gidx_q, pick;
    logic [CW-1:0] waste_q;
    logic          found;

    // rotating search from the pointer
    always_comb begin
        found = 1'b0;
        pick  = ptr_q;
        for (int k = 0; k < N_IN; k++) begin
            int idx;
            idx = int'(ptr_q) + k;
            if (idx >= N_IN) idx = idx - N_IN;
            if (!found && req[idx]) begin
                found = 1'b1;
                pick  = IW'(idx);
            end
        end
    end

    // next-state logic
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ARB_IDLE:  if (slot && found) st_d = ARB_GRANT;
            ARB_GRANT: st_d = ARB_IDLE;
            default:   st_d = ARB_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q    <= ARB_IDLE;
            ptr_q   <= '0;
            gidx_q  <= '0;
            waste_q <= '0;
        end else begin
            st_q <= st_d;
            if ((st_q == ARB_IDLE) && (st_d == ARB_GRANT)) begin
                gidx_q <= pick;
                ptr_q  <= (pick == TOP) ? '0 : pick + 1'b1;
            end
            if ((st_q == ARB_GRANT) && !hit && (waste_q != '1)) begin
                waste_q <= waste_q + 1'b1;
            end
        end
    end

    // outputs
    always_comb begin
        grant_vld  = (st_q == ARB_GRANT);
        grant_idx  = gidx_q;
        wasted_cnt = waste_q;
    end

endmodule

// File: rtl/voq_sched.sv
module voq_sched
    import voq_pkg::*;
#(
    parameter int N_IN  = 4,
    parameter int N_OUT = 4,
    parameter int DEPTH = 4,
    parameter int DW    = 8,
    parameter int CW    = 8,
    parameter int IW    = (N_IN > 1) ? $clog2(N_IN) : 1,
    parameter int OW    = (N_OUT > 1) ? $clog2(N_OUT) : 1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [N_IN-1:0]          in_vld,
    input  logic [N_IN*OW-1:0]       in_dst,
    input  logic [N_IN*DW-1:0]       in_data,
    input  logic [N_OUT-1:0]         out_ready,
    output logic [N_OUT-1:0]         out_vld,
    output logic [N_OUT*IW-1:0]      out_src,
    output logic [N_OUT*DW-1:0]      out_data,
    output logic [N_IN*N_OUT-1:0]    voq_req,
    output logic [N_IN*N_OUT*CW-1:0] drop_cnt,
    output logic [N_OUT*CW-1:0]      wasted_cnt
);

    logic [DW-1:0]   head_w     [N_IN][N_OUT];
    logic            nonempty_w [N_IN][N_OUT];
    logic            req_w      [N_IN][N_OUT];
    logic            gvld_w     [N_OUT];
    logic [IW-1:0]   gidx_w     [N_OUT];
    logic [N_IN-1:0] req_pk     [N_OUT];
    logic [DW-1:0]   sel_data   [N_OUT];
    logic [N_OUT-1:0] hit;

    for (genvar i = 0; i < N_IN; i++) begin : g_in
        for (genvar o = 0; o < N_OUT; o++) begin : g_q
            logic push_w, pop_w;
            assign push_w = in_vld[i] && (in_dst[i*OW +: OW] == OW'(o));
            assign pop_w  = gvld_w[o] && (gidx_w[o] == IW'(i));

            voq_queue #(
                .DEPTH(DEPTH),
                .DW   (DW),
                .CW   (CW)
            ) u_queue (
                .clk      (clk),
                .rst_n    (rst_n),
                .push     (push_w),
                .push_data(in_data[i*DW +: DW]),
                .pop      (pop_w),
                .head_data(head_w[i][o]),
                .nonempty (nonempty_w[i][o]),
                .req      (req_w[i][o]),
                .drop_cnt (drop_cnt[(i*N_OUT+o)*CW +: CW])
            );

            assign voq_req[i*N_OUT+o] = req_w[i][o];
        end
    end

    always_comb begin
        for (int o = 0; o < N_OUT; o++) begin
            for (int i = 0; i < N_IN; i++) begin
                req_pk[o][i] = req_w[i][o];
            end
        end
    end

    always_comb begin
        for (int o = 0; o < N_OUT; o++) begin
            hit[o]      = 1'b0;
            sel_data[o] = '0;
            for (int i = 0; i < N_IN; i++) begin
                if (gidx_w[o] == IW'(i)) begin
                    hit[o]      = nonempty_w[i][o];
                    sel_data[o] = head_w[i][o];
                end
            end
        end
    end

    for (genvar o = 0; o < N_OUT; o++) begin : g_out
        voq_rr_arb #(
            .N_IN(N_IN),
            .IW  (IW),
            .CW  (CW)
        ) u_arb (
            .clk       (clk),
            .rst_n     (rst_n),
            .req       (req_pk[o]),
            .slot      (out_ready[o]),
            .hit       (hit[o]),
            .grant_vld (gvld_w[o]),
            .grant_idx (gidx_w[o]),
            .wasted_cnt(wasted_cnt[o*CW +: CW])
        );

        assign out_vld[o]              = gvld_w[o] && hit[o];
        assign out_src[o*IW +: IW]     = gidx_w[o];
        assign out_data[o*DW +: DW]    = sel_data[o];
    end

endmodule

// File: rtl/voq_sched_chk.sv
module voq_sched_chk #(
    parameter int N_IN  = 4,
    parameter int N_OUT = 4,
    parameter int DEPTH = 4,
    parameter int DW    = 8,
    parameter int CW    = 8,
    parameter int IW    = 2,
    parameter int OW    = 2
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic [N_IN-1:0]          in_vld,
    input logic [N_IN*OW-1:0]       in_dst,
    input logic [N_IN*DW-1:0]       in_data,
    input logic [N_OUT-1:0]         out_ready,
    input logic [N_OUT-1:0]         out_vld,
    input logic [N_OUT*IW-1:0]      out_src,
    input logic [N_OUT*DW-1:0]      out_data,
    input logic [N_IN*N_OUT-1:0]    voq_req,
    input logic [N_IN*N_OUT*CW-1:0] drop_cnt,
    input logic [N_OUT*CW-1:0]      wasted_cnt
);

    for (genvar o = 0; o < N_OUT; o++) begin : g_o
        // R2: a released descriptor needs a slot in the decision cycle
        a_r2_slot_first: assert property (@(posedge clk) disable iff (!rst_n)
            out_vld[o] |-> $past(out_ready[o]));

        // R6: never two releases back to back on one output
        a_r6_spaced: assert property (@(posedge clk) disable iff (!rst_n)
            out_vld[o] |=> !out_vld[o]);

        // R7: wasted count steps by one and only after a cycle with no release
        a_r7_wasted_step: assert property (@(posedge clk) disable iff (!rst_n)
            (wasted_cnt[o*CW +: CW] != $past(wasted_cnt[o*CW +: CW])) |->
            ((wasted_cnt[o*CW +: CW] == CW'($past(wasted_cnt[o*CW +: CW]) + 1'b1))
             && !$past(out_vld[o])));

        for (genvar i = 0; i < N_IN; i++) begin : g_i
            // R3: a release from a queue follows a request from that queue
            a_r3_req_first: assert property (@(posedge clk) disable iff (!rst_n)
                (out_vld[o] && (out_src[o*IW +: IW] == IW'(i))) |->
                $past(voq_req[i*N_OUT+o]));

            // R8: drop count only ever steps up by one
            a_r8_drop_step: assert property (@(posedge clk) disable iff (!rst_n)
                (drop_cnt[(i*N_OUT+o)*CW +: CW] != $past(drop_cnt[(i*N_OUT+o)*CW +: CW])) |->
                (drop_cnt[(i*N_OUT+o)*CW +: CW] ==
                 CW'($past(drop_cnt[(i*N_OUT+o)*CW +: CW]) + 1'b1)));
        end
    end

endmodule

bind voq_sched voq_sched_chk #(
    .N_IN (N_IN),
    .N_OUT(N_OUT),
    .DEPTH(DEPTH),
    .DW   (DW),
    .CW   (CW),
    .IW   (IW),
    .OW   (OW)
) u_chk (.*);

// File: tb/voq_sched_tb.sv
module voq_sched_tb;

    localparam int CLK_PERIOD = 10;
    localparam int N_IN  = 4;
    localparam int N_OUT = 4;
    localparam int DEPTH = 4;
    localparam int DW    = 8;
    localparam int CW    = 8;
    localparam int IW    = 2;
    localparam int OW    = 2;

    logic                     clk = 1'b0;
    logic                     rst_n;
    logic [N_IN-1:0]          in_vld;
    logic [N_IN*OW-1:0]       in_dst;
    logic [N_IN*DW-1:0]       in_data;
    logic [N_OUT-1:0]         out_ready;
    logic [N_OUT-1:0]         out_vld;
    logic [N_OUT*IW-1:0]      out_src;
    logic [N_OUT*DW-1:0]      out_data;
    logic [N_IN*N_OUT-1:0]    voq_req;
    logic [N_IN*N_OUT*CW-1:0] drop_cnt;
    logic [N_OUT*CW-1:0]      wasted_cnt;

    int total = 0;
    int bad   = 0;
    int expq [N_OUT][$];
    int stg  [N_IN][N_OUT][$];
    int ptr_m    [N_OUT];
    int wasted_m [N_OUT];
    int drop_m   [N_IN*N_OUT];
    bit prev_vld [N_OUT];
    bit both_seen = 1'b0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    voq_sched #(
        .N_IN(N_IN), .N_OUT(N_OUT), .DEPTH(DEPTH), .DW(DW), .CW(CW), .IW(IW), .OW(OW)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .in_dst(in_dst), .in_data(in_data),
        .out_ready(out_ready), .out_vld(out_vld), .out_src(out_src), .out_data(out_data),
        .voq_req(voq_req), .drop_cnt(drop_cnt), .wasted_cnt(wasted_cnt)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // scoreboard monitor: pops expected (src,data) per output
    always @(negedge clk) begin
        if (rst_n) begin
            if (out_vld[1] && out_vld[2]) both_seen = 1'b1;
            for (int o = 0; o < N_OUT; o++) begin
                if (out_vld[o]) begin
                    int got;
                    got = (int'(out_src[o*IW +: IW]) << 8) | int'(out_data[o*DW +: DW]);
                    chk(!prev_vld[o], "R6 back-to-back release", 1, 0);
                    if (expq[o].size() == 0) begin
                        chk(1'b0, "R2 release without expected grant", got, -1);
                    end else begin
                        int want;
                        want = expq[o].pop_front();
                        chk(got == want, "R1/R5 release order (src<<8|data)", got, want);
                    end
                end
                prev_vld[o] = out_vld[o];
            end
        end
    end

    task automatic push(input int i, input int o, input int d);
        @(negedge clk);
        in_vld = '0;
        in_vld[i] = 1'b1;
        in_dst[i*OW +: OW] = OW'(o);
        in_data[i*DW +: DW] = DW'(d);
        if (stg[i][o].size() < DEPTH) stg[i][o].push_back(d);
        else drop_m[i*N_OUT+o]++;
    endtask

    task automatic quiet();
        @(negedge clk);
        in_vld = '0;
    endtask

    // round-robin expectation for output o from staged descriptors
    task automatic release_out(input int o);
        bit any = 1'b0;
        bit more = 1'b1;
        while (more) begin
            more = 1'b0;
            for (int k = 0; k < N_IN; k++) begin
                int idx;
                idx = (ptr_m[o] + k) % N_IN;
                if (!more && stg[idx][o].size() != 0) begin
                    int d;
                    d = stg[idx][o].pop_front();
                    expq[o].push_back((idx << 8) | d);
                    ptr_m[o] = (idx + 1) % N_IN;
                    more = 1'b1;
                    any = 1'b1;
                end
            end
        end
        if (any) wasted_m[o]++;
    endtask

    task automatic drain(input int o);
        int guard = 0;
        while (expq[o].size() != 0 && guard < 300) begin
            @(negedge clk);
            guard++;
        end
        chk(expq[o].size() == 0, "R6 all granted descriptors released", expq[o].size(), 0);
        repeat (6) @(negedge clk);
        out_ready[o] = 1'b0;
        chk(int'(wasted_cnt[o*CW +: CW]) == wasted_m[o], "R7 wasted grant count",
            int'(wasted_cnt[o*CW +: CW]), wasted_m[o]);
        for (int i = 0; i < N_IN; i++) begin
            chk(voq_req[i*N_OUT+o] == 1'b0, "R3 request clears after drain",
                int'(voq_req[i*N_OUT+o]), 0);
        end
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL R6 watchdog actual=hang expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        for (int o = 0; o < N_OUT; o++) begin
            ptr_m[o] = 0;
            wasted_m[o] = 0;
            prev_vld[o] = 1'b0;
        end
        for (int q = 0; q < N_IN*N_OUT; q++) drop_m[q] = 0;
        rst_n = 1'b0;
        in_vld = '0;
        in_dst = '0;
        in_data = '0;
        out_ready = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R9: reset state
        chk(out_vld == '0, "R9 no release after reset", int'(out_vld), 0);
        chk(voq_req == '0, "R9 no request after reset", int'(voq_req), 0);
        chk(drop_cnt == '0, "R9 drop counters zero", 0, 0);
        chk(wasted_cnt == '0, "R9 wasted counters zero", int'(wasted_cnt), 0);

        // R2/R3: hold with no slot on output 2
        push(0, 2, 8'h11);
        push(0, 2, 8'h12);
        quiet();
        repeat (10) @(negedge clk);
        chk(voq_req[0*N_OUT+2] == 1'b1, "R3 request raised while queue holds",
            int'(voq_req[0*N_OUT+2]), 1);
        chk(out_vld[2] == 1'b0, "R2 nothing leaves without slot", int'(out_vld[2]), 0);
        release_out(2);
        out_ready[2] = 1'b1;
        drain(2);

        // R4: local traffic input 1 -> output 1 still waits for grant
        push(1, 1, 8'h21);
        quiet();
        repeat (8) @(negedge clk);
        chk(voq_req[1*N_OUT+1] == 1'b1, "R4 local queue requests", int'(voq_req[1*N_OUT+1]), 1);
        chk(out_vld[1] == 1'b0, "R4 local descriptor held until grant", int'(out_vld[1]), 0);
        release_out(1);
        out_ready[1] = 1'b1;
        drain(1);

        // R5: three inputs contend for output 3
        for (int n = 0; n < 3; n++) begin
            for (int i = 0; i < 3; i++) push(i, 3, 8'h30 + i*16 + n);
        end
        quiet();
        repeat (4) @(negedge clk);
        release_out(3);
        out_ready[3] = 1'b1;
        drain(3);

        // R7: single descriptor alone on output 0
        push(3, 0, 8'h41);
        quiet();
        release_out(0);
        out_ready[0] = 1'b1;
        drain(0);

        // R10: outputs 1 and 2 release in parallel
        push(0, 1, 8'h51);
        push(0, 2, 8'h52);
        push(3, 1, 8'h53);
        quiet();
        repeat (4) @(negedge clk);
        release_out(1);
        release_out(2);
        out_ready[1] = 1'b1;
        out_ready[2] = 1'b1;
        drain(1);
        drain(2);
        chk(both_seen, "R10 two outputs released in one cycle", int'(both_seen), 1);

        // R8: overfill queue (2,0)
        for (int n = 0; n < DEPTH + 2; n++) push(2, 0, 8'h60 + n);
        quiet();
        repeat (3) @(negedge clk);
        chk(int'(drop_cnt[(2*N_OUT+0)*CW +: CW]) == drop_m[2*N_OUT+0], "R8 drops counted",
            int'(drop_cnt[(2*N_OUT+0)*CW +: CW]), drop_m[2*N_OUT+0]);
        chk(int'(drop_cnt[(1*N_OUT+0)*CW +: CW]) == 0, "R8 other queue untouched",
            int'(drop_cnt[(1*N_OUT+0)*CW +: CW]), 0);
        release_out(0);
        out_ready[0] = 1'b1;
        drain(0);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule